// File: doc/BRIEF.md
# Oversampling Serial Receiver with Per-Character Error Queue

This block turns an asynchronous serial line back into characters. A free-running clock enable, pulsing sixteen times per bit period, paces the sampling. After a falling edge the receiver looks at the line again in the middle of the start bit, and drops edges that were only glitches. It then takes every data bit, the optional parity bit and the first stop bit once each, in the centre of the bit. The character length runs from five to eight bits, and parity can be even, odd or off.

Each completed character goes into a receive queue with three status bits: parity error, framing error and break. A status bit therefore always stays with the character that caused it. In queue mode the buffer holds sixteen characters. In character mode it holds one, and acts as a plain holding register. The reader sees the head entry all the time and removes it with a one-cycle read strobe. A data-ready flag, an active-low receive-ready pin for a DMA engine and a sticky overrun flag complete the interface.

Top module: `rxq_receiver`

## Requirements
- R1: A low level seen on a sampling tick starts a character only if the line is still low 8 ticks later, at the centre of the start bit. If the line has returned high by then, nothing is stored and the receiver goes back to looking for a start bit.
- R2: Data bits arrive LSB first and are each sampled once, 16 ticks after the previous sample. `char_len` selects the length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the selected length read as zero.
- R3: When `parity_en`=1, one parity bit follows the data. `parity_odd`=1 selects odd parity and 0 selects even. A mismatch sets `rd_perr` on that character. When `parity_en`=0, `rd_perr` is always 0.
- R4: If the first stop bit is sampled low, `rd_ferr` is set on that character.
- R5: A frame in which the data bits, the parity bit (if enabled) and the stop bit are all low stores exactly one entry with data 0, `rd_brk`=1, `rd_ferr`=1 and `rd_perr`=0. The receiver then waits for the line to go high before it looks for another start bit.
- R6: With `fifo_mode`=1 the queue holds up to 16 characters and returns them in arrival order, each with its own status bits.
- R7: With `fifo_mode`=0 the buffer holds one character.
- R8: A character that completes while the buffer is full is discarded and the stored entries are left unchanged. `overrun` is set and stays set until `ovr_clr` is pulsed.
- R9: `data_ready`=1 and `rxrdy_n`=0 whenever the buffer holds a character. The head entry is visible on the read outputs, and `rd_en` removes it.
- R10: After reset the buffer is empty (`data_ready`=0, `rxrdy_n`=1) and `overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sampling enable, 16 pulses per bit |
| rx_in | input | 1 | Serial line, idle high |
| fifo_mode | input | 1 | 1: 16-entry queue, 0: single holding register |
| char_len | input | 2 | Data length code (0..3 gives 5..8 bits) |
| parity_en | input | 1 | Parity bit present |
| parity_odd | input | 1 | 1 odd, 0 even parity |
| rd_en | input | 1 | Removes the head entry |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry break |
| data_ready | output | 1 | Buffer not empty |
| overrun | output | 1 | Sticky overrun flag |
| rxrdy_n | output | 1 | Active-low receive ready for DMA |

## Verification
The bench sends a short low pulse on the line. A receiver that skipped the mid-start check would turn that glitch into a spurious all-ones character. It sends a 5-bit frame with high bits set in the source value. A design that fails to mask the unused positions would return stray ones there. It holds the line low for longer than a frame. A receiver that resumed hunting at once would store several break entries instead of one. It fills both the 16-entry queue and the single holding register past capacity. A design that overwrote on overrun would lose the oldest character or return the newest one.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rxq_entry_t;

  typedef enum logic [2:0] {
    ST_HUNT, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
  } rxq_state_e;
endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxq_framer.sv
module rxq_framer
  import rxq_pkg::*;
#(
  parameter int TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] char_len,
  input  logic       parity_en,
  input  logic       parity_odd,
  output logic       push,
  output rxq_entry_t entry
);
  localparam int CW = $clog2(TICKS);
  localparam logic [CW-1:0] MID  = CW'(TICKS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  rxq_state_e state, n_state;
  logic [CW-1:0] cnt, n_cnt;
  logic [2:0]    bidx, n_bidx;
  logic [7:0]    sh, n_sh;
  logic          pbit, n_pbit;
  logic          n_push;
  rxq_entry_t    n_entry;
  logic [2:0]    last_bit;
  logic          is_brk;

  assign last_bit = {1'b0, char_len} + 3'd4;
  assign is_brk   = !line && (sh == 8'h00) && !(parity_en && pbit);

  always_comb begin
    n_state = state;
    n_cnt   = cnt;
    n_bidx  = bidx;
    n_sh    = sh;
    n_pbit  = pbit;
    n_push  = 1'b0;
    n_entry = entry;
    case (state)
      ST_HUNT: if (tick && !line) begin
        n_state = ST_START;
        n_cnt   = '0;
        n_sh    = '0;
        n_pbit  = 1'b0;
      end
      ST_START: if (tick) begin
        if (cnt == MID) begin
          n_cnt   = '0;
          n_bidx  = '0;
          n_state = line ? ST_HUNT : ST_DATA;
        end else n_cnt = cnt + 1'b1;
      end
      ST_DATA: if (tick) begin
        if (cnt == LAST) begin
          n_cnt      = '0;
          n_sh[bidx] = line;
          if (bidx == last_bit) n_state = parity_en ? ST_PAR : ST_STOP;
          else                  n_bidx  = bidx + 1'b1;
        end else n_cnt = cnt + 1'b1;
      end
      ST_PAR: if (tick) begin
        if (cnt == LAST) begin
          n_cnt   = '0;
          n_pbit  = line;
          n_state = ST_STOP;
        end else n_cnt = cnt + 1'b1;
      end
      ST_STOP: if (tick) begin
        if (cnt == LAST) begin
          n_push        = 1'b1;
          n_entry.data  = sh;
          n_entry.ferr  = !line;
          n_entry.brk   = is_brk;
          n_entry.perr  = parity_en && !is_brk && ((^sh) ^ pbit ^ parity_odd);
          n_state       = line ? ST_HUNT : ST_HOLD;
        end else n_cnt = cnt + 1'b1;
      end
      ST_HOLD: if (tick && line) n_state = ST_HUNT;
      default: n_state = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HUNT;
      cnt   <= '0;
      bidx  <= '0;
      sh    <= '0;
      pbit  <= 1'b0;
      push  <= 1'b0;
      entry <= '0;
    end else begin
      state <= n_state;
      cnt   <= n_cnt;
      bidx  <= n_bidx;
      sh    <= n_sh;
      pbit  <= n_pbit;
      push  <= n_push;
      entry <= n_entry;
    end
  end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode,
  input  logic       push,
  input  rxq_entry_t din,
  input  logic       pop,
  output rxq_entry_t dout,
  output logic       full,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  rxq_entry_t mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cap;
  logic          do_push, do_pop;

  assign cap     = fifo_mode ? LW'(DEPTH) : LW'(1);
  assign full    = (level >= cap);
  assign do_push = push && !full;
  assign do_pop  = pop && (level != '0);
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wrap_inc(wr_ptr);
      if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
      if (do_push && !do_pop)      level <= level + 1'b1;
      else if (do_pop && !do_push) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/rxq_receiver.sv
module rxq_receiver
  import rxq_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int TICKS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_in,
  input  logic       fifo_mode,
  input  logic [1:0] char_len,
  input  logic       parity_en,
  input  logic       parity_odd,
  input  logic       rd_en,
  input  logic       ovr_clr,
  output logic [7:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       rd_brk,
  output logic       data_ready,
  output logic       overrun,
  output logic       rxrdy_n
);
  localparam int LW = $clog2(DEPTH+1);

  logic [1:0]    rst_pipe;
  logic          rst_int_n;
  logic          line_s;
  logic          push, full;
  rxq_entry_t    entry, head;
  logic [LW-1:0] level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  rxq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(rx_in), .q(line_s)
  );

  rxq_framer #(.TICKS(TICKS)) u_framer (
    .clk(clk), .rst_n(rst_int_n), .tick(tick16), .line(line_s),
    .char_len(char_len), .parity_en(parity_en), .parity_odd(parity_odd),
    .push(push), .entry(entry)
  );

  rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_int_n), .fifo_mode(fifo_mode),
    .push(push), .din(entry), .pop(rd_en), .dout(head),
    .full(full), .level(level)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)        overrun <= 1'b0;
    else if (push && full) overrun <= 1'b1;
    else if (ovr_clr)      overrun <= 1'b0;
  end

  assign data_ready = (level != '0);
  assign rxrdy_n    = (level == '0);
  assign rd_data    = head.data;
  assign rd_perr    = head.perr;
  assign rd_ferr    = head.ferr;
  assign rd_brk     = head.brk;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fifo_mode,
  input logic                       rd_en,
  input logic                       ovr_clr,
  input logic [7:0]                 rd_data,
  input logic                       rd_brk,
  input logic                       data_ready,
  input logic                       rxrdy_n,
  input logic                       overrun,
  input logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int LW = $clog2(DEPTH+1);
  logic [LW-1:0] cap;
  assign cap = fifo_mode ? LW'(DEPTH) : LW'(1);

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);

  // R6
  fifo_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R7
  char_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && $stable(fifo_mode)) |-> level <= LW'(1));

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == cap && !rd_en && $stable(fifo_mode)) |=> level == $past(level));

  // R5
  brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && rd_brk) |-> rd_data == 8'h00);

  // R9
  ready_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready == (level != '0)) && (rxrdy_n == !data_ready));
endmodule

bind rxq_receiver rxq_checker #(.DEPTH(DEPTH)) u_rxq_chk (
  .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rd_en(rd_en),
  .ovr_clr(ovr_clr), .rd_data(rd_data), .rd_brk(rd_brk),
  .data_ready(data_ready), .rxrdy_n(rxrdy_n), .overrun(overrun),
  .level(level)
);

// File: tb/rxq_receiver_bench.sv
module rxq_receiver_bench;
  logic clk = 1'b0;
  logic rst_n, tick16, rx_in, fifo_mode, parity_en, parity_odd, rd_en, ovr_clr;
  logic [1:0] char_len;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rd_brk, data_ready, overrun, rxrdy_n;
  logic [1:0] tdiv = 2'd0;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  rxq_receiver u_rxq_receiver (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
    .fifo_mode(fifo_mode), .char_len(char_len), .parity_en(parity_en),
    .parity_odd(parity_odd), .rd_en(rd_en), .ovr_clr(ovr_clr),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .data_ready(data_ready), .overrun(overrun), .rxrdy_n(rxrdy_n)
  );

  // {char_len, parity_en, parity_odd, data, parity flipped}
  localparam int NV = 6;
  localparam logic [12:0] VEC [NV] = '{
    {2'd3, 1'b0, 1'b0, 8'hA5, 1'b0},
    {2'd0, 1'b1, 1'b0, 8'h13, 1'b0},
    {2'd1, 1'b1, 1'b1, 8'h2C, 1'b1},
    {2'd2, 1'b1, 1'b0, 8'h7F, 1'b1},
    {2'd3, 1'b1, 1'b1, 8'h00, 1'b0},
    {2'd0, 1'b0, 1'b0, 8'hFF, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick16) @(posedge clk);
    end
    #1;
  endtask

  task automatic hold(input logic v, input int bits);
    rx_in = v;
    ticks(16 * bits);
  endtask

  task automatic send(input int nb, input logic [7:0] d, input logic pen,
                      input logic pb, input logic stopv);
    hold(1'b0, 1);
    for (int i = 0; i < nb; i++) hold(d[i], 1);
    if (pen) hold(pb, 1);
    hold(stopv, 1);
    rx_in = 1'b1;
    ticks(8);
  endtask

  task automatic pop();
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
  endtask

  task automatic clear_ovr();
    @(negedge clk) ovr_clr = 1'b1;
    @(negedge clk) ovr_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_in = 1'b1; fifo_mode = 1'b1; char_len = 2'd3;
    parity_en = 1'b0; parity_odd = 1'b0; rd_en = 1'b0; ovr_clr = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 data_ready", data_ready, 0);
    check("R10 rxrdy_n", rxrdy_n, 1);
    check("R10 overrun", overrun, 0);
    ticks(4);

    // R2 R3 table walk
    for (int v = 0; v < NV; v++) begin
      automatic logic [1:0] ln = VEC[v][12:11];
      automatic logic pe = VEC[v][10];
      automatic logic po = VEC[v][9];
      automatic logic [7:0] dv = VEC[v][8:1];
      automatic logic fl = VEC[v][0];
      automatic int nb = int'(ln) + 5;
      automatic logic [7:0] msk = 8'hFF >> (8 - nb);
      automatic logic pb = (^(dv & msk)) ^ po ^ fl;
      char_len = ln; parity_en = pe; parity_odd = po;
      send(nb, dv, pe, pb, 1'b1);
      @(negedge clk);
      check("R9 ready", {data_ready, rxrdy_n}, 2'b10);
      check("R2 data", rd_data, dv & msk);
      check("R3 perr", rd_perr, pe & fl);
      check("R4 ferr clear", {rd_ferr, rd_brk}, 2'b00);
      pop();
      check("R9 empty after read", data_ready, 0);
    end

    // R1 false start
    char_len = 2'd3; parity_en = 1'b0;
    rx_in = 1'b0; ticks(4);
    rx_in = 1'b1; ticks(16 * 12);
    @(negedge clk);
    check("R1 false start stores nothing", data_ready, 0);

    // R4 framing error
    send(8, 8'h55, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R4 ferr", {data_ready, rd_ferr, rd_brk, rd_data}, {3'b110, 8'h55});
    pop();

    // R5 break held longer than a frame, odd parity enabled
    parity_en = 1'b1; parity_odd = 1'b1;
    hold(1'b0, 16);
    rx_in = 1'b1; ticks(40);
    @(negedge clk);
    check("R5 break entry", {rd_brk, rd_ferr, rd_perr, rd_data}, {3'b110, 8'h00});
    pop();
    check("R5 single break entry", data_ready, 0);
    parity_en = 1'b0; parity_odd = 1'b0;

    // R6 R8 queue overrun
    for (int i = 0; i < 17; i++) send(8, 8'(i + 8'h40), 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check("R8 overrun set", overrun, 1);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check("R6 order", rd_data, 8'(i + 8'h40));
      pop();
    end
    check("R8 newest discarded", data_ready, 0);
    ticks(20);
    @(negedge clk);
    check("R8 overrun sticky", overrun, 1);
    clear_ovr();
    check("R8 overrun cleared", overrun, 0);

    // R7 character mode
    fifo_mode = 1'b0;
    send(8, 8'h11, 1'b0, 1'b0, 1'b1);
    send(8, 8'h22, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check("R7 overrun at one", overrun, 1);
    check("R7 first kept", rd_data, 8'h11);
    pop();
    check("R7 capacity one", data_ready, 0);
    clear_ovr();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule